// File: doc/BRIEF.md
# Series-Product Single-Precision Divider

This block divides two single-precision floating-point words with a fixed-point reciprocal series rather than a digit recurrence. Both significands are brought into [0.5, 1). If the dividend is not below the divisor, the dividend is halved so that the quotient lies in [0.5, 1). The divisor is then complemented to z = 1 - y. The quotient is built as x(1+z)(1+z^2)(1+z^4)... on one shared multiplier. Each loop pass squares z and folds (1+z) into the running product. The loop ends when the squared term truncates to zero or when the pass limit is reached. The product is rounded half-up, renormalized and repacked. The exponent difference is applied directly to the exponent field.

Operands enter on a valid/ready input. Only one division is in flight, so the input is ready only while the block is idle. The result leaves on a valid/ready output that honours back-pressure. The quotient word and its four status flags stay frozen while `out_valid` is high and `out_ready` is low. The block does not take a new operand pair until the result has been accepted.

Special operands are flagged rather than fully handled. Infinities and NaNs give a quiet NaN. Subnormals are flushed to zero. A zero divisor gives a signed infinity. The rounding is not a selectable IEEE mode.

Top module: `sp_series_div`

## Requirements
- R1: A pair of operands is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the result has been taken. `in_ready` and `out_valid` are never high together.
- R2: Every result that is not the NaN pattern has bit 31 equal to the XOR of the two operand bit-31 signs.
- R3: Words carry the sign in bit 31, a biased exponent (bias 127) in bits 30:23 and the fraction in bits 22:0. For normal operands with a normal quotient, bits 30:0 of the result are within one unit of the exactly divided value truncated to 23 fraction bits.
- R4: When both significands are equal, or the divisor significand is 1.0, the quotient is exact.
- R5: A non-zero finite dividend over a zero divisor raises `out_div_zero` and returns a signed infinity (magnitude 0x7F800000).
- R6: A zero dividend over a non-zero finite divisor returns a signed zero with all flags low.
- R7: An operand with exponent field 255 raises `out_invalid` and returns 0x7FC00000.
- R8: A subnormal operand (exponent field 0, fraction not 0) raises `out_invalid` and is treated as zero, so R5 and R6 then apply to it. Zero over zero gives `out_invalid` and 0x7FC00000.
- R9: A biased result exponent above 254 returns a signed infinity with `out_overflow` high.
- R10: A biased result exponent below 1 returns a signed zero with `out_underflow` high. A result with exponent exactly 1 is returned as a normal word with no flag.
- R11: `out_valid` rises at most 20 cycles after the operands are taken.
- R12: While `out_valid` is high and `out_ready` is low, the quotient and all flags hold their values and `out_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take operands |
| in_dividend | input | 32 | Dividend word |
| in_divisor | input | 32 | Divisor word |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_quotient | output | 32 | Quotient word |
| out_div_zero | output | 1 | Divisor was zero |
| out_invalid | output | 1 | Infinity, NaN or subnormal operand, or zero over zero |
| out_overflow | output | 1 | Result exponent above the normal range |
| out_underflow | output | 1 | Result exponent below the normal range |

## Verification
The main path is tried with divisor significands close to 2.0, where z is tiny and the loop stops early. It is also tried with a divisor significand of exactly 1.0, where z is 0.5 and every pass is needed. Pairs with the dividend significand above or below the divisor's separate the halving path from the direct path. Equal significands show whether the rounding recovers an exact power of two from a product that falls just short. Exponent pairs that land on 254, 255, 1 and below 1 check both saturation edges. The output is stalled on a repeating pattern, so a result that drifts under back-pressure is caught.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int WORD_W  = 32;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int BIAS    = 127;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int EW      = EXP_W + 3;

  localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNPK, ST_MULR, ST_SQR, ST_PACK, ST_OUT
  } spd_state_t;

  typedef struct packed {
    logic is_zero;
    logic is_sub;
    logic is_spec;
  } spd_class_t;

  typedef struct packed {
    logic dz;
    logic inv;
    logic ovf;
    logic unf;
  } spd_flags_t;

  function automatic logic [WORD_W-1:0] signed_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] signed_zero(input logic s);
    return {s, {(WORD_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/spd_unpack.sv
module spd_unpack
  import spd_pkg::*;
#(
  parameter int DP_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output spd_class_t        cls,
  output logic              sign,
  output logic [EXP_W-1:0]  expo,
  output logic [DP_W-1:0]   sig
);
  localparam int GB = DP_W - 2 - FRAC_W;

  logic [FRAC_W-1:0] frac;

  assign sign = word[WORD_W-1];
  assign expo = word[WORD_W-2 -: EXP_W];
  assign frac = word[FRAC_W-1:0];

  always_comb begin
    cls.is_spec = (expo == EXP_W'(EXP_MAX));
    cls.is_zero = (expo == '0) && (frac == '0);
    cls.is_sub  = (expo == '0) && (frac != '0);
  end

  // significand 1.f scaled by one half: bit DP_W-2 carries weight 0.5
  assign sig = {1'b0, 1'b1, frac, {GB{1'b0}}};
endmodule

// File: rtl/spd_mult.sv
module spd_mult #(
  parameter int DP_W = 32
) (
  input  logic [DP_W-1:0] op_a,
  input  logic [DP_W-1:0] op_b,
  output logic [DP_W-1:0] prod
);
  logic [2*DP_W-1:0] full;
  logic              unused_bits;

  assign full = op_a * op_b;
  // Q1.(DP_W-1) times Q1.(DP_W-1) gives Q2.(2*DP_W-2); keep the aligned window
  assign prod = full[2*DP_W-2 -: DP_W];
  assign unused_bits = full[2*DP_W-1] ^ (^full[DP_W-2:0]);
endmodule

// File: rtl/spd_pack.sv
module spd_pack
  import spd_pkg::*;
#(
  parameter int DP_W = 32
) (
  input  logic                 sign,
  input  logic [DP_W-1:0]      q,
  input  logic signed [EW-1:0] exp_base,
  output logic [WORD_W-1:0]    word,
  output logic                 ovf,
  output logic                 unf
);
  localparam int GB = DP_W - 2 - FRAC_W;
  localparam logic [DP_W-1:0] HALF_HI = DP_W'(1) << (GB - 1);
  localparam logic [DP_W-1:0] HALF_LO = DP_W'(1) << (GB - 2);
  localparam logic signed [EW-1:0] E_TOP = EW'(EXP_MAX - 1);
  localparam logic signed [EW-1:0] E_BOT = EW'(1);

  logic [DP_W-1:0]      qr;
  logic [FRAC_W-1:0]    man;
  logic signed [EW-1:0] e_fin;
  logic                 unused_q;

  // round half-up at the position the mantissa will end on
  assign qr = q + (q[DP_W-2] ? HALF_HI : HALF_LO);

  always_comb begin
    if (qr[DP_W-2]) begin
      man   = qr[DP_W-3 -: FRAC_W];
      e_fin = exp_base;
    end else begin
      man   = qr[DP_W-4 -: FRAC_W];
      e_fin = exp_base - EW'(1);
    end
  end

  assign unused_q = qr[DP_W-1] ^ (^qr[GB-2:0]);

  always_comb begin
    ovf  = 1'b0;
    unf  = 1'b0;
    word = {sign, e_fin[EXP_W-1:0], man};
    if (e_fin > E_TOP) begin
      ovf  = 1'b1;
      word = signed_inf(sign);
    end else if (e_fin < E_BOT) begin
      unf  = 1'b1;
      word = signed_zero(sign);
    end
  end
endmodule

// File: rtl/sp_series_div.sv
module sp_series_div
  import spd_pkg::*;
#(
  parameter int DP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_dividend,
  input  logic [WORD_W-1:0] in_divisor,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_quotient,
  output logic              out_div_zero,
  output logic              out_invalid,
  output logic              out_overflow,
  output logic              out_underflow
);
  localparam int ITERS = $clog2(DP_W);
  localparam int IW    = $clog2(ITERS + 1);
  localparam logic [DP_W-1:0] ONE = {1'b1, {(DP_W-1){1'b0}}};
  localparam logic signed [EW-1:0] BIAS_M1 = EW'(BIAS - 1);

  spd_state_t state;
  logic [WORD_W-1:0] opa_r, opb_r;
  logic [DP_W-1:0]   r_r, z_r;
  logic signed [EW-1:0] exp_r;
  logic [IW-1:0]     iter_r;
  logic              sign_r;
  logic [WORD_W-1:0] res_r;
  spd_flags_t        flg_r;

  spd_class_t        ca, cb;
  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb;
  logic [DP_W-1:0]   siga, sigb;

  spd_unpack #(.DP_W(DP_W)) u_unp_a (
    .word(opa_r), .cls(ca), .sign(sa), .expo(ea), .sig(siga)
  );
  spd_unpack #(.DP_W(DP_W)) u_unp_b (
    .word(opb_r), .cls(cb), .sign(sb), .expo(eb), .sig(sigb)
  );

  logic [DP_W-1:0] mul_a, mul_b, prod;
  assign mul_a = (state == ST_SQR) ? z_r : r_r;
  assign mul_b = (state == ST_SQR) ? z_r : (ONE + z_r);

  spd_mult #(.DP_W(DP_W)) u_mul (.op_a(mul_a), .op_b(mul_b), .prod(prod));

  logic [WORD_W-1:0] pk_word;
  logic              pk_ovf, pk_unf;
  spd_pack #(.DP_W(DP_W)) u_pack (
    .sign(sign_r), .q(r_r), .exp_base(exp_r),
    .word(pk_word), .ovf(pk_ovf), .unf(pk_unf)
  );

  // operand classification, evaluated in ST_UNPK
  logic sgn, any_spec, any_sub, zero_a, zero_b, ge;
  logic signed [EW-1:0] exp_diff;
  always_comb begin
    sgn      = sa ^ sb;
    any_spec = ca.is_spec | cb.is_spec;
    any_sub  = ca.is_sub | cb.is_sub;
    zero_a   = ca.is_zero | ca.is_sub;
    zero_b   = cb.is_zero | cb.is_sub;
    ge       = (siga >= sigb);
    exp_diff = $signed(EW'(ea)) - $signed(EW'(eb)) + BIAS_M1 + (ge ? EW'(1) : EW'(0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      opa_r  <= '0;
      opb_r  <= '0;
      r_r    <= '0;
      z_r    <= '0;
      exp_r  <= '0;
      iter_r <= '0;
      sign_r <= 1'b0;
      res_r  <= '0;
      flg_r  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            opa_r <= in_dividend;
            opb_r <= in_divisor;
            flg_r <= '0;
            state <= ST_UNPK;
          end
        end
        ST_UNPK: begin
          sign_r <= sgn;
          if (any_spec) begin
            res_r     <= QNAN_WORD;
            flg_r.inv <= 1'b1;
            state     <= ST_OUT;
          end else if (zero_b) begin
            if (zero_a) begin
              res_r     <= QNAN_WORD;
              flg_r.inv <= 1'b1;
            end else begin
              res_r     <= signed_inf(sgn);
              flg_r.dz  <= 1'b1;
              flg_r.inv <= any_sub;
            end
            state <= ST_OUT;
          end else if (zero_a) begin
            res_r     <= signed_zero(sgn);
            flg_r.inv <= any_sub;
            state     <= ST_OUT;
          end else begin
            r_r    <= ge ? (siga >> 1) : siga;
            z_r    <= ONE - sigb;
            exp_r  <= exp_diff;
            iter_r <= '0;
            state  <= ST_MULR;
          end
        end
        ST_MULR: begin
          r_r   <= prod;
          state <= ST_SQR;
        end
        ST_SQR: begin
          z_r    <= prod;
          iter_r <= iter_r + IW'(1);
          if ((prod == '0) || (iter_r == IW'(ITERS - 1))) state <= ST_PACK;
          else                                            state <= ST_MULR;
        end
        ST_PACK: begin
          res_r     <= pk_word;
          flg_r.ovf <= pk_ovf;
          flg_r.unf <= pk_unf;
          state     <= ST_OUT;
        end
        ST_OUT: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready      = (state == ST_IDLE);
  assign out_valid     = (state == ST_OUT);
  assign out_quotient  = res_r;
  assign out_div_zero  = flg_r.dz;
  assign out_invalid   = flg_r.inv;
  assign out_overflow  = flg_r.ovf;
  assign out_underflow = flg_r.unf;
endmodule

// File: rtl/spd_chk.sv
module spd_chk #(
  parameter int LAT_LIMIT = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_dividend,
  input logic [31:0] in_divisor,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_quotient,
  input logic        out_div_zero,
  input logic        out_invalid,
  input logic        out_overflow,
  input logic        out_underflow
);
  logic       exp_sign;
  logic [7:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_sign <= 1'b0;
      lat_cnt  <= '0;
    end else if (in_valid && in_ready) begin
      exp_sign <= in_dividend[31] ^ in_divisor[31];
      lat_cnt  <= '0;
    end else if (!in_ready && !out_valid && lat_cnt != 8'hFF) begin
      lat_cnt <= lat_cnt + 8'd1;
    end
  end

  // R1
  hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R1
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quotient) &&
      $stable(out_div_zero) && $stable(out_invalid) &&
      $stable(out_overflow) && $stable(out_underflow)));

  // R2
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_quotient[30:22] != 9'h1FF)) |-> (out_quotient[31] == exp_sign));

  // R5
  div_zero_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_div_zero) |-> (out_quotient[30:0] == 31'h7F800000));

  // R9
  overflow_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> (out_quotient[30:0] == 31'h7F800000));

  // R10
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_underflow) |-> (out_quotient[30:0] == 31'h0));

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_cnt <= 8'(LAT_LIMIT));
endmodule

bind sp_series_div spd_chk u_spd_chk (.*);

// File: tb/sp_series_div_tb_top.sv
`timescale 1ns/1ps
module sp_series_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_dividend = '0;
  logic [31:0] in_divisor = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_quotient;
  logic        out_div_zero, out_invalid, out_overflow, out_underflow;

  int n_run = 0;
  int n_fail = 0;

  logic [31:0] exp_q[$];
  logic [3:0]  flg_q[$];
  bit          tol_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  sp_series_div dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_quotient(out_quotient),
    .out_div_zero(out_div_zero), .out_invalid(out_invalid),
    .out_overflow(out_overflow), .out_underflow(out_underflow)
  );

  function automatic real f2r(input logic [31:0] w);
    logic [63:0] d;
    int e;
    e = int'(w[30:23]) - 127 + 1023;
    d = {w[31], 11'(e), w[22:0], 29'b0};
    return $bitstoreal(d);
  endfunction

  // exact quotient truncated to single precision (normal range only)
  function automatic logic [31:0] ref_div(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] d;
    int e;
    d = $realtobits(f2r(a) / f2r(b));
    e = int'(d[62:52]) - 1023 + 127;
    return {d[63], 8'(e), d[51:29]};
  endfunction

  task automatic check(input string tag, input bit ok, input logic [31:0] act,
                       input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  // driver: queue the expectation, then offer the operands
  task automatic send(input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] expv, input logic [3:0] flg,
                      input bit tol, input string tag);
    int lat;
    exp_q.push_back(expv);
    flg_q.push_back(flg);
    tol_q.push_back(tol);
    tag_q.push_back(tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = a;
    in_divisor  = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 ready drops after transfer", !in_ready, {31'b0, in_ready}, 32'h0);
    lat = 1;
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R11 latency", lat <= 20, 32'(lat), 32'd20);
  endtask

  task automatic send_num(input logic [31:0] a, input logic [31:0] b, input string tag);
    send(a, b, ref_div(a, b), 4'b0000, 1'b1, tag);
  endtask

  // output back-pressure pattern
  int rdy_cnt = 0;
  initial forever begin
    @(posedge clk);
    #1;
    rdy_cnt++;
    out_ready = (rdy_cnt % 4) != 1;
  end

  // monitor
  logic        held = 1'b0;
  logic [35:0] held_val;
  initial forever begin
    @(negedge clk);
    if (held) begin
      check("R12 hold under stall",
            out_valid && ({out_quotient, out_div_zero, out_invalid, out_overflow, out_underflow} == held_val),
            out_quotient, held_val[35:4]);
    end
    held = 1'b0;
    if (out_valid && !out_ready) begin
      held     = 1'b1;
      held_val = {out_quotient, out_div_zero, out_invalid, out_overflow, out_underflow};
    end else if (out_valid && out_ready && exp_q.size() > 0) begin
      logic [31:0] e;
      logic [3:0]  f;
      bit          t;
      string       g;
      bit          ok;
      int          diff;
      e = exp_q.pop_front();
      f = flg_q.pop_front();
      t = tol_q.pop_front();
      g = tag_q.pop_front();
      diff = int'(out_quotient[30:0]) - int'(e[30:0]);
      if (t) ok = (out_quotient[31] == e[31]) && (diff >= -1) && (diff <= 1);
      else   ok = (out_quotient == e);
      ok = ok && ({out_div_zero, out_invalid, out_overflow, out_underflow} == f);
      check(g, ok, out_quotient, e);
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset ready", in_ready === 1'b1, {31'b0, in_ready}, 32'h1);
    check("R1 reset no output", out_valid === 1'b0, {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;

    // R3 general quotients
    send_num(32'h40400000, 32'h40E00000, "R3 3/7");
    send_num(32'h41200000, 32'h40400000, "R3 10/3");
    send_num(32'h42F6E979, 32'h3F49FBE7, "R3 123.456/0.789");
    send_num(32'h3F800001, 32'h3FFFFFFF, "R3 divisor near 2");
    send_num(32'h3FFFFFFF, 32'h3F800001, "R3 dividend near 2");
    send_num(32'hC0B00000, 32'h40100000, "R2 R3 -5.5/2.25");
    send_num(32'h501502F9, 32'hBBE56042, "R2 R3 large/-small");
    // R4 exact cases
    send(32'h3F800000, 32'h3F800000, 32'h3F800000, 4'b0000, 1'b0, "R4 1/1");
    send(32'h40C00000, 32'h40400000, 32'h40000000, 4'b0000, 1'b0, "R4 6/3");
    send(32'h40E00000, 32'h3F800000, 32'h40E00000, 4'b0000, 1'b0, "R4 7/1");
    send(32'hC1000000, 32'h40000000, 32'hC0800000, 4'b0000, 1'b0, "R4 R2 -8/2");
    send(32'h3F400000, 32'hBEC00000, 32'hC0000000, 4'b0000, 1'b0, "R4 R2 0.75/-0.375");
    // R5 divide by zero; flags {dz,inv,ovf,unf}
    send(32'h40400000, 32'h00000000, 32'h7F800000, 4'b1000, 1'b0, "R5 3/+0");
    send(32'h40400000, 32'h80000000, 32'hFF800000, 4'b1000, 1'b0, "R5 R2 3/-0");
    send(32'hC0400000, 32'h80000000, 32'h7F800000, 4'b1000, 1'b0, "R5 R2 -3/-0");
    // R6 zero dividend
    send(32'h00000000, 32'h40400000, 32'h00000000, 4'b0000, 1'b0, "R6 +0/3");
    send(32'h80000000, 32'h40400000, 32'h80000000, 4'b0000, 1'b0, "R6 R2 -0/3");
    // R7 exponent all ones
    send(32'h7F800000, 32'h40000000, 32'h7FC00000, 4'b0100, 1'b0, "R7 inf/2");
    send(32'h40000000, 32'h7FC00001, 32'h7FC00000, 4'b0100, 1'b0, "R7 2/nan");
    // R8 subnormals and 0/0
    send(32'h00000001, 32'h40000000, 32'h00000000, 4'b0100, 1'b0, "R8 sub/2");
    send(32'h3F800000, 32'h80400000, 32'hFF800000, 4'b1100, 1'b0, "R8 1/-sub");
    send(32'h00000000, 32'h00000000, 32'h7FC00000, 4'b0100, 1'b0, "R8 0/0");
    // R9 overflow and top edge
    send(32'h7F000000, 32'h3A800000, 32'h7F800000, 4'b0010, 1'b0, "R9 2^127/2^-10");
    send(32'h7F400000, 32'hBF400000, 32'hFF800000, 4'b0010, 1'b0, "R9 R2 exponent 255");
    send(32'h7F000000, 32'h3F800000, 32'h7F000000, 4'b0000, 1'b0, "R9 exponent 254 kept");
    // R10 underflow and bottom edge
    send(32'h03800000, 32'h49800000, 32'h00000000, 4'b0001, 1'b0, "R10 2^-120/2^20");
    send(32'h01000000, 32'h40000000, 32'h00800000, 4'b0000, 1'b0, "R10 exponent 1 kept");
    send(32'h00800000, 32'hC0000000, 32'h80000000, 4'b0001, 1'b0, "R10 R2 exponent 0");

    wait (exp_q.size() == 0);
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule